// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a first-level cache whose main array is direct-mapped, with a small fully associative victim buffer placed on the refill path between that array and the next memory level. When a request misses the direct-mapped array, the victim buffer is searched in the same cycle. If the line is found there, the buffered line and the line that currently occupies the conflicting set trade places, and the request completes one cycle later without any memory traffic. If the line is in neither place, it is fetched from memory. The line that the refill displaces from the direct-mapped array is moved into the victim buffer. The newly fetched line is not copied there.

The CPU side is a single read/write port. The CPU holds its request, address and write data steady while `cpu_stall` is high. An access completes on the first rising edge at which `cpu_req` is high and `cpu_stall` is low. Read data is valid in that same cycle. The memory side carries one line per transfer. The cache holds `mem_req` together with the address, direction and write data until memory returns a single-cycle `mem_ack`. On a read, the line arrives on `mem_rdata` in the acknowledge cycle. A line is one data word, and addresses are line addresses. The low `IDX_W` bits of the address select the set.

Top module: `vc_cache`

## Requirements
- R1: After a synchronous active-low reset, no line is valid in either structure. `cpu_stall` and `mem_req` are low while no request is present, and the first access to any address is a full miss.
- R2: A read that hits the direct-mapped array returns the stored data with `cpu_stall` low in the same cycle. A write that hits updates the line and marks it dirty, also with no stall.
- R3: On a miss in both structures, the cache issues a memory read (`mem_we`=0) for the requested line address. It keeps `mem_req`, `mem_addr` and `mem_we` stable until `mem_ack`, and holds `cpu_stall` high until the refill has been installed. Writes that miss allocate the line first and then write it.
- R4: On a refill, the valid line displaced from the direct-mapped set moves into the victim buffer together with its data and dirty state. The fetched line is not placed in the victim buffer.
- R5: A primary miss that hits the victim buffer swaps the two lines in one operation. It raises `cpu_stall` for exactly one cycle and makes no memory request.
- R6: A line address is never valid in both the direct-mapped array and the victim buffer, and at most one victim entry matches any address.
- R7: An insertion into the victim buffer uses a free entry if one exists. Otherwise it replaces the least recently used entry. Both inserts and hits make the touched entry the most recently used.
- R8: When a dirty victim entry must be replaced, a memory write (`mem_we`=1) of its address and latest data completes before the refill read starts. Replacing a clean entry causes no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Access request, held while stalled |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Line address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid when request is high and stall is low |
| cpu_stall | output | 1 | Access not yet complete |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = line read |
| mem_addr | output | ADDR_W | Line address of the transfer |
| mem_wdata | output | DATA_W | Write-back data |
| mem_ack | input | 1 | One-cycle completion of the transfer |
| mem_rdata | input | DATA_W | Refill data, valid with mem_ack |

## Verification
The hardest situation to reach is a write-back that is decided by recency. A dirty line must reach the least-recently-used position of a full victim buffer, while victim hits reorder the entries on the way. The stimulus drives one chain of conflicting addresses into a single set. It dirties lines by writing to them, pulls lines back out of the buffer with victim hits, and then streams new conflicting lines until the dirty entry becomes the oldest. The bench predicts the exact access on which each write-back appears, and its memory model compares the written data with the last value the CPU stored.

// File: rtl/vc_pkg.sv
// Shared types for the victim-buffered cache.
package vc_pkg;
    // Controller phases: serve CPU, write back a dirty victim, refill a line.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WB   = 2'd1,
        ST_FILL = 2'd2
    } ctl_state_t;
endpackage

// File: rtl/vc_dm_array.sv
// Direct-mapped line store: one entry per set holding valid, dirty, tag and data.
// Assumes one read index (combinational) and one write per cycle.
module vc_dm_array #(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_dirty,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0]   set_v;
    logic [SETS-1:0]   set_d;
    logic [TAG_W-1:0]  set_t [SETS];
    logic [DATA_W-1:0] set_q [SETS];

    // Read the addressed set.
    always_comb begin
        rd_valid = set_v[rd_idx];
        rd_dirty = set_d[rd_idx];
        rd_tag   = set_t[rd_idx];
        rd_data  = set_q[rd_idx];
    end

    // Clear valid bits on reset; otherwise write the selected set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_v <= '0;
            set_d <= '0;
        end else if (wr_en) begin
            set_v[wr_idx] <= 1'b1;
            set_d[wr_idx] <= wr_dirty;
            set_t[wr_idx] <= wr_tag;
            set_q[wr_idx] <= wr_data;
        end
    end
endmodule

// File: rtl/vc_victim_store.sv
// Fully associative victim buffer with recency ages (0 = most recent).
// Assumes the controller never inserts an address that is already present.
module vc_victim_store #(
    parameter int ENTRIES = 4,
    parameter int LA_W    = 12,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LA_W-1:0]   look_addr,
    output logic              hit,
    output logic [(ENTRIES>1?$clog2(ENTRIES):1)-1:0] hit_slot,
    output logic              hit_dirty,
    output logic [DATA_W-1:0] hit_data,
    output logic [(ENTRIES>1?$clog2(ENTRIES):1)-1:0] sel_slot,
    output logic              sel_valid,
    output logic              sel_dirty,
    output logic [LA_W-1:0]   sel_addr,
    output logic [DATA_W-1:0] sel_data,
    input  logic              wr_en,
    input  logic [(ENTRIES>1?$clog2(ENTRIES):1)-1:0] wr_slot,
    input  logic              wr_valid,
    input  logic              wr_dirty,
    input  logic              wr_touch,
    input  logic [LA_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] ent_v;
    logic [ENTRIES-1:0] ent_d;
    logic [LA_W-1:0]    ent_a [ENTRIES];
    logic [DATA_W-1:0]  ent_q [ENTRIES];
    logic [SLOT_W-1:0]  age   [ENTRIES];
    logic [ENTRIES-1:0] hit_vec;

    // Per-entry address comparators.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = ent_v[g] && (ent_a[g] == look_addr);
    end

    // Encode the matching entry.
    always_comb begin
        hit_slot = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (hit_vec[i]) hit_slot = SLOT_W'(i);
        hit       = |hit_vec;
        hit_dirty = ent_d[hit_slot];
        hit_data  = ent_q[hit_slot];
    end

    // Choose the insertion slot: lowest free entry, else the oldest one.
    always_comb begin
        logic found;
        logic [SLOT_W-1:0] best;
        found    = 1'b0;
        sel_slot = '0;
        best     = age[0];
        for (int i = 0; i < ENTRIES; i++) begin
            if (!ent_v[i] && !found) begin
                sel_slot = SLOT_W'(i);
                found    = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 1; i < ENTRIES; i++) begin
                if (age[i] > best) begin
                    best     = age[i];
                    sel_slot = SLOT_W'(i);
                end
            end
        end
        sel_valid = ent_v[sel_slot];
        sel_dirty = ent_d[sel_slot];
        sel_addr  = ent_a[sel_slot];
        sel_data  = ent_q[sel_slot];
    end

    // Update entry contents and recency ages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_v <= '0;
            ent_d <= '0;
            for (int i = 0; i < ENTRIES; i++) age[i] <= SLOT_W'(i);
        end else if (wr_en) begin
            ent_v[wr_slot] <= wr_valid;
            ent_d[wr_slot] <= wr_dirty;
            ent_a[wr_slot] <= wr_addr;
            ent_q[wr_slot] <= wr_data;
            if (wr_touch) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (SLOT_W'(i) == wr_slot) age[i] <= '0;
                    else if (age[i] < age[wr_slot]) age[i] <= age[i] + 1'b1;
                end
            end
        end
    end

    // R6: at most one entry may match an address.
    p_one_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R7: recency ages stay a permutation (pairwise distinct).
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ai
        for (genvar j = i + 1; j < ENTRIES; j++) begin : g_aj
            p_age_distinct_r7: assert property (@(posedge clk) disable iff (!rst_n)
                age[i] != age[j]);
        end
    end
endmodule

// File: rtl/vc_cache.sv
// Top: direct-mapped cache with a victim buffer on its refill path.
// Assumes the CPU holds request, address and data while cpu_stall is high,
// and memory answers every request with one mem_ack pulse.
module vc_cache #(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 32,
    parameter int VB_N   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    import vc_pkg::*;

    localparam int TAG_W  = ADDR_W - IDX_W;
    localparam int SLOT_W = (VB_N > 1) ? $clog2(VB_N) : 1;

    ctl_state_t state, state_nx;

    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic              rd_valid, rd_dirty;
    logic [TAG_W-1:0]  rd_tag;
    logic [DATA_W-1:0] rd_data;
    logic              arr_we, arr_dirty;
    logic [DATA_W-1:0] arr_data;
    logic              p_hit;

    logic              v_hit, v_hit_dirty;
    logic [SLOT_W-1:0] v_hit_slot, v_sel_slot, vb_slot;
    logic [DATA_W-1:0] v_hit_data, v_sel_data;
    logic              v_sel_valid, v_sel_dirty;
    logic [ADDR_W-1:0] v_sel_addr;
    logic              vb_we, vb_valid, vb_touch;

    assign idx   = cpu_addr[IDX_W-1:0];
    assign tag   = cpu_addr[ADDR_W-1:IDX_W];
    assign p_hit = rd_valid && (rd_tag == tag);

    vc_dm_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(idx), .rd_valid(rd_valid), .rd_dirty(rd_dirty),
        .rd_tag(rd_tag), .rd_data(rd_data),
        .wr_en(arr_we), .wr_idx(idx), .wr_dirty(arr_dirty),
        .wr_tag(tag), .wr_data(arr_data)
    );

    vc_victim_store #(.ENTRIES(VB_N), .LA_W(ADDR_W), .DATA_W(DATA_W)) u_victim (
        .clk(clk), .rst_n(rst_n),
        .look_addr(cpu_addr), .hit(v_hit), .hit_slot(v_hit_slot),
        .hit_dirty(v_hit_dirty), .hit_data(v_hit_data),
        .sel_slot(v_sel_slot), .sel_valid(v_sel_valid), .sel_dirty(v_sel_dirty),
        .sel_addr(v_sel_addr), .sel_data(v_sel_data),
        .wr_en(vb_we), .wr_slot(vb_slot), .wr_valid(vb_valid),
        .wr_dirty(rd_dirty), .wr_touch(vb_touch),
        .wr_addr({rd_tag, idx}), .wr_data(rd_data)
    );

    // Sequence hits, swaps, write-backs and refills.
    always_comb begin
        state_nx  = state;
        arr_we    = 1'b0;
        arr_dirty = 1'b0;
        arr_data  = cpu_wdata;
        vb_we     = 1'b0;
        vb_slot   = v_sel_slot;
        vb_valid  = rd_valid;
        vb_touch  = 1'b1;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cpu_addr;
        mem_wdata = v_sel_data;
        case (state)
            ST_IDLE: begin
                if (cpu_req && p_hit) begin
                    arr_we    = cpu_we;
                    arr_dirty = 1'b1;
                end else if (cpu_req && v_hit) begin
                    arr_we    = 1'b1;
                    arr_dirty = v_hit_dirty;
                    arr_data  = v_hit_data;
                    vb_we     = 1'b1;
                    vb_slot   = v_hit_slot;
                end else if (cpu_req) begin
                    state_nx = (rd_valid && v_sel_valid && v_sel_dirty) ? ST_WB : ST_FILL;
                end
            end
            ST_WB: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = v_sel_addr;
                if (mem_ack) begin
                    vb_we    = 1'b1;
                    vb_valid = 1'b0;
                    vb_touch = 1'b0;
                    state_nx = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    arr_we    = 1'b1;
                    arr_data  = mem_rdata;
                    vb_we     = rd_valid;
                    state_nx  = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign cpu_stall = cpu_req && !((state == ST_IDLE) && p_hit);
    assign cpu_rdata = rd_data;

    // Controller state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // R6: a line never sits in both structures.
    p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && p_hit) |-> !v_hit);

    // R5: a victim swap costs one stall cycle and no memory traffic.
    p_swap_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cpu_req && !p_hit && v_hit) |=>
        (!cpu_req || cpu_addr != $past(cpu_addr) || !cpu_stall));
    p_swap_no_mem_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && v_hit && !p_hit && state == ST_IDLE) |-> !mem_req);

    // R3: memory request is held stable until acknowledged.
    p_mem_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    p_stall_in_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && state != ST_IDLE) |-> cpu_stall);

    // R8: only a valid dirty victim is ever written back.
    p_wb_dirty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (v_sel_valid && v_sel_dirty));
endmodule

// File: tb/tb_vc_cache.sv
// Scoreboard bench: the driver queues expected read data, a monitor compares it.
module tb_vc_cache;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 3;
    localparam int ADDR_W     = 12;
    localparam int DATA_W     = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0, cpu_rdata;
    logic cpu_stall, mem_req, mem_we, mem_ack;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;

    int checks = 0, fails = 0, fills = 0, wbs = 0, cycles = 0;
    logic [DATA_W-1:0] exp_q [$];
    logic [DATA_W-1:0] mem_m [int];
    logic [DATA_W-1:0] gold  [int];

    vc_cache dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DATA_W-1:0] init_val(int a);
        return 32'hC0DE_0000 | DATA_W'(a);
    endfunction
    function automatic logic [DATA_W-1:0] mem_rd(int a);
        return mem_m.exists(a) ? mem_m[a] : init_val(a);
    endfunction
    function automatic logic [DATA_W-1:0] gold_rd(int a);
        return gold.exists(a) ? gold[a] : init_val(a);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory model: acknowledges after MEM_LAT request cycles, checks write-backs.
    initial begin
        int cnt;
        cnt = 0;
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                cnt = 0;
            end else if (rst_n && mem_req) begin
                cnt++;
                if (cnt == MEM_LAT) begin
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        wbs++;
                        chk(mem_wdata == gold_rd(int'(mem_addr)), "R8 write-back data",
                            mem_wdata, gold_rd(int'(mem_addr)));
                        mem_m[int'(mem_addr)] = mem_wdata;
                    end else begin
                        fills++;
                        mem_rdata = mem_rd(int'(mem_addr));
                    end
                end
            end
        end
    end

    // Monitor: compares every completed read against the scoreboard queue.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && cpu_req && !cpu_stall && !cpu_we) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected read completion", cpu_rdata, '0);
                end else begin
                    logic [DATA_W-1:0] e;
                    e = exp_q.pop_front();
                    chk(cpu_rdata == e, "R2/R3 read data", cpu_rdata, e);
                end
            end
        end
    end

    // Driver: cls 0 = primary hit, 1 = victim hit, 2 = full miss.
    task automatic access(input bit we, input int a, input logic [DATA_W-1:0] d,
                          input int cls, input int dfill, input int dwb, input string tag);
        int f0, w0, stalls;
        @(negedge clk);
        f0 = fills;
        w0 = wbs;
        cpu_req = 1'b1;
        cpu_we = we;
        cpu_addr = ADDR_W'(a);
        cpu_wdata = d;
        if (we) gold[a] = d;
        else exp_q.push_back(gold_rd(a));
        stalls = 0;
        #1;
        while (cpu_stall) begin
            @(negedge clk);
            #1;
            stalls++;
        end
        if (cls == 2) chk(stalls >= 2, {tag, " stall cycles"}, DATA_W'(stalls), 32'd2);
        else chk(stalls == cls, {tag, " stall cycles"}, DATA_W'(stalls), DATA_W'(cls));
        chk(fills - f0 == dfill, {tag, " refills"}, DATA_W'(fills - f0), DATA_W'(dfill));
        chk(wbs - w0 == dwb, {tag, " write-backs"}, DATA_W'(wbs - w0), DATA_W'(dwb));
    endtask

    function automatic int conf(int k);
        return k << 2;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cpu_stall, "R1 stall idle after reset", DATA_W'(cpu_stall), 0);
        chk(!mem_req, "R1 no memory request after reset", DATA_W'(mem_req), 0);

        access(0, conf(0), '0, 2, 1, 0, "R1 R3 cold read");
        access(0, conf(0), '0, 0, 0, 0, "R2 read hit");
        access(1, conf(0), 32'hD000_0000, 0, 0, 0, "R2 write hit");
        access(0, conf(1), '0, 2, 1, 0, "R3 conflict miss");
        access(0, conf(0), '0, 1, 0, 0, "R4 R5 evicted line from buffer");
        access(0, conf(1), '0, 1, 0, 0, "R5 R6 swap back");
        access(0, 1, '0, 2, 1, 0, "R3 other set miss");
        access(0, conf(2), '0, 2, 1, 0, "R7 free slot 2");
        access(0, conf(3), '0, 2, 1, 0, "R7 free slot 3");
        access(0, conf(4), '0, 2, 1, 0, "R7 free slot 4");
        access(0, conf(5), '0, 2, 1, 1, "R8 dirty LRU written back");
        access(0, conf(0), '0, 2, 1, 0, "R8 written-back line refetched");
        access(0, conf(2), '0, 1, 0, 0, "R7 hit makes entry recent");
        access(1, conf(3), 32'hD000_0003, 1, 0, 0, "R5 write via swap");
        access(0, conf(6), '0, 2, 1, 0, "R8 clean LRU dropped");
        access(0, conf(7), '0, 2, 1, 0, "R7 clean eviction");
        access(0, conf(8), '0, 2, 1, 0, "R7 clean eviction 2");
        access(0, conf(9), '0, 2, 1, 0, "R7 clean eviction 3");
        access(0, conf(10), '0, 2, 1, 1, "R7 R8 dirty entry reaches LRU");
        access(0, conf(3), '0, 2, 1, 0, "R8 dirty data returned by memory");
        access(1, conf(11), 32'hD000_000B, 2, 1, 0, "R3 write allocate");
        access(0, conf(11), '0, 0, 0, 0, "R3 allocated write readable");

        @(negedge clk);
        cpu_req = 1'b0;
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all reads observed", DATA_W'(exp_q.size()), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                chk(1'b0, "watchdog expired", DATA_W'(cycles), 32'd20000);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end
endmodule